// File: doc/BRIEF.md
# Write-Only I2C Configuration Bank for a Four-Channel Sensor Front End

This block is a receive-only I2C slave that holds the settings of a four-channel sensor amplifier. It never drives SDA: both bus lines are plain inputs. Each channel gets an offset DAC code, a gain-select code and an active-low power-down flag. One more active-low flag powers down the shared current and voltage references. A bus master writes the whole bank in one transaction. It addresses the slave, then sends the setting bytes in a fixed order.

The logic runs from an auxiliary clock at twice the SCL rate, aligned to the SCL falling edge. SCL and SDA are sampled on every rising clock edge. START and STOP are recognised when SDA moves while SCL stays high across two consecutive samples. A data bit is taken on the first sample in which SCL is high. The slave cannot pull SDA low, so its acknowledge is an internal one-cycle strobe. The ninth clock pulse of every byte is skipped.

The bank resets to all zeros, which powers everything down. A per-channel flag reports any stored gain code outside the four legal patterns.

Top module: `i2c_wr_cfg_bank`

## Requirements
- R1: While `rst` is high and after its release, every offset code, gain code, channel enable and the reference enable read 0, `ackStrobe` is 0 and every `gainBad` bit is 1 (gain code 0000 is illegal).
- R2: Bits are taken MSB first, one per sample on which SCL is seen high after being seen low. The ninth SCL pulse of each byte (the acknowledge slot) is not stored.
- R3: A START is SDA going 1 to 0 between two consecutive samples that both show SCL high. A STOP is SDA going 0 to 1 under the same condition. Any START, including a repeated START without a STOP, restarts the address phase and the bank byte index at 0. A STOP returns the slave to idle.
- R4: `ackStrobe` is a single-cycle pulse, high two clock cycles after the sample that carries the eighth bit of an accepted byte. An accepted byte is a matching address byte or a stored data byte.
- R5: The first byte after START must equal 0x08 (7-bit address 0000100, write bit 0). Any other value, a read bit included, makes the slave ignore the rest of the transaction: no register changes and no `ackStrobe` until the next START.
- R6: Data bytes fill the bank in this order: channel 0 offset, channel 0 control, then the same pair for channels 1 to 3, then the reference byte. The bank registers change only in the cycle in which `ackStrobe` is high.
- R7: In a control byte, bit 7 is the channel enable (0 = powered down) and bits 3..0 are the gain bits S1..S4, with S1 at bit 3. Bits 6..4 are ignored.
- R8: In the reference byte, bit 0 is the reference enable (0 = powered down). The other bits are ignored.
- R9: Data bytes received after the ninth bank byte are discarded without `ackStrobe`, and the bank keeps its values.
- R10: The legal gain codes are 0101 (5x2), 0110 (5x20), 1001 (25x2) and 1010 (25x20). Any other code is stored unchanged, and its channel's `gainBad` bit is 1. `gainBad` changes only when that channel's gain code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Auxiliary clock at twice the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| sclIn | input | 1 | I2C clock line (input only) |
| sdaIn | input | 1 | I2C data line (input only) |
| ackStrobe | output | 1 | One-cycle pulse per accepted byte |
| offsetCode | output | 32 | Offset DAC codes, channel n at bits 8n+7..8n |
| gainSel | output | 16 | Gain codes S1..S4, channel n at bits 4n+3..4n |
| chanPwdN | output | 4 | Channel enables, 0 = powered down |
| refPwdN | output | 1 | Reference enable, 0 = powered down |
| gainBad | output | 4 | Per-channel illegal gain code flag |

## Verification
Some properties are checked on every cycle. The acknowledge pulse lasts one cycle and always follows an SCL rise seen three and two samples earlier. The bank registers never move outside an acknowledge cycle, and the gain flags never change while the gain codes hold still. Other behaviour depends on what was on the bus, so only the bench's transaction scenarios can show it. That covers address rejection, read-bit rejection, bank overflow, repeated START, field placement within the control and reference bytes, and bit order. The bench also checks the exact flag value for each stored gain code.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  // Receiver framing state
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rxState_t;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic frameStart;  // START seen: clear byte index
    logic shiftEn;     // take sdaBit into the shift register
    logic byteEnd;     // this shift completes a byte
    logic addrByte;    // the completing byte is the address byte
  } rxStrobe_t;

  // The four gain patterns that select 5x2, 5x20, 25x2, 25x20
  function automatic logic gainLegal(input logic [3:0] code);
    case (code)
      4'b0101, 4'b0110, 4'b1001, 4'b1010: gainLegal = 1'b1;
      default:                            gainLegal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2c_cfg_ctl.sv
module i2c_cfg_ctl
  import i2c_cfg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      addrHit,
  output rxStrobe_t strb,
  output logic      sdaBit
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  logic sclQ, sclQQ, sdaQ, sdaQQ;
  logic startSeen, stopSeen, sclRise, inByte;
  rxState_t state;
  logic [CNT_W-1:0] bitCnt;

  // Two-deep sample history of both bus lines; idle bus is high
  always_ff @(posedge clk) begin
    if (rst) begin
      sclQ  <= 1'b1;
      sclQQ <= 1'b1;
      sdaQ  <= 1'b1;
      sdaQQ <= 1'b1;
    end else begin
      sclQ  <= sclIn;
      sclQQ <= sclQ;
      sdaQ  <= sdaIn;
      sdaQQ <= sdaQ;
    end
  end

  assign startSeen = sclQ & sclQQ &  sdaQQ & ~sdaQ;
  assign stopSeen  = sclQ & sclQQ & ~sdaQQ &  sdaQ;
  assign sclRise   = sclQ & ~sclQQ;
  assign inByte    = (state == ST_ADDR) || (state == ST_DATA);
  assign sdaBit    = sdaQ;

  always_comb begin
    strb            = '0;
    strb.frameStart = startSeen;
    strb.shiftEn    = inByte & sclRise & (bitCnt != ACK_SLOT);
    strb.byteEnd    = inByte & sclRise & (bitCnt == LAST_BIT);
    strb.addrByte   = (state == ST_ADDR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (startSeen) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopSeen) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (inByte && sclRise) begin
      bitCnt <= (bitCnt == ACK_SLOT) ? '0 : bitCnt + 1'b1;
      if (bitCnt == LAST_BIT && state == ST_ADDR)
        state <= addrHit ? ST_DATA : ST_SKIP;
    end
  end

endmodule

// File: rtl/i2c_cfg_dp.sv
module i2c_cfg_dp
  import i2c_cfg_pkg::*;
#(
  parameter int         NUM_CH   = 4,
  parameter int         BYTE_W   = 8,
  parameter logic [6:0] DEV_ADDR = 7'b0000100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  rxStrobe_t                strb,
  input  logic                     sdaBit,
  output logic                     addrHit,
  output logic                     ackStrobe,
  output logic [NUM_CH*BYTE_W-1:0] offsetCode,
  output logic [NUM_CH*4-1:0]      gainSel,
  output logic [NUM_CH-1:0]        chanPwdN,
  output logic                     refPwdN,
  output logic [NUM_CH-1:0]        gainBad
);

  localparam int NUM_REG = 2 * NUM_CH + 1;
  localparam int IDX_W   = $clog2(NUM_REG + 1);
  localparam logic [IDX_W-1:0] REF_IDX = IDX_W'(2 * NUM_CH);
  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(NUM_REG);

  logic [BYTE_W-1:0] shiftReg, nextByte;
  logic [IDX_W-1:0]  byteIdx;
  logic              dataTake;

  assign nextByte = {shiftReg[BYTE_W-2:0], sdaBit};
  assign addrHit  = (nextByte == BYTE_W'({DEV_ADDR, 1'b0}));
  assign dataTake = strb.byteEnd & ~strb.addrByte & (byteIdx < END_IDX);

  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= nextByte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byteIdx   <= '0;
      ackStrobe <= 1'b0;
    end else begin
      ackStrobe <= (strb.byteEnd & strb.addrByte & addrHit) | dataTake;
      if (strb.frameStart)  byteIdx <= '0;
      else if (dataTake)    byteIdx <= byteIdx + 1'b1;
    end
  end

  // One offset and one control slot per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam logic [IDX_W-1:0] OFF_IDX = IDX_W'(2 * ch);
    localparam logic [IDX_W-1:0] CTL_IDX = IDX_W'(2 * ch + 1);
    logic [BYTE_W-1:0] offReg;
    logic [3:0]        gainReg;
    logic              enReg;

    always_ff @(posedge clk) begin
      if (rst) begin
        offReg  <= '0;
        gainReg <= '0;
        enReg   <= 1'b0;
      end else if (dataTake) begin
        if (byteIdx == OFF_IDX) offReg <= nextByte;
        if (byteIdx == CTL_IDX) begin
          gainReg <= nextByte[3:0];
          enReg   <= nextByte[BYTE_W-1];
        end
      end
    end

    assign offsetCode[ch*BYTE_W +: BYTE_W] = offReg;
    assign gainSel[ch*4 +: 4]              = gainReg;
    assign chanPwdN[ch]                    = enReg;
    assign gainBad[ch]                     = ~gainLegal(gainReg);
  end

  always_ff @(posedge clk) begin
    if (rst) refPwdN <= 1'b0;
    else if (dataTake && byteIdx == REF_IDX) refPwdN <= nextByte[0];
  end

endmodule

// File: rtl/i2c_wr_cfg_bank.sv
module i2c_wr_cfg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int         NUM_CH   = 4,
  parameter int         BYTE_W   = 8,
  parameter logic [6:0] DEV_ADDR = 7'b0000100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  output logic                     ackStrobe,
  output logic [NUM_CH*BYTE_W-1:0] offsetCode,
  output logic [NUM_CH*4-1:0]      gainSel,
  output logic [NUM_CH-1:0]        chanPwdN,
  output logic                     refPwdN,
  output logic [NUM_CH-1:0]        gainBad
);

  rxStrobe_t strb;
  logic      sdaBit, addrHit;

  i2c_cfg_ctl #(.BYTE_W(BYTE_W)) u_ctl (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .strb(strb), .sdaBit(sdaBit)
  );

  i2c_cfg_dp #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .DEV_ADDR(DEV_ADDR)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .sdaBit(sdaBit),
    .addrHit(addrHit), .ackStrobe(ackStrobe), .offsetCode(offsetCode),
    .gainSel(gainSel), .chanPwdN(chanPwdN), .refPwdN(refPwdN),
    .gainBad(gainBad)
  );

endmodule

// File: rtl/i2c_cfg_chk.sv
module i2c_cfg_chk #(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sclIn,
  input logic                     ackStrobe,
  input logic [NUM_CH*BYTE_W-1:0] offsetCode,
  input logic [NUM_CH*4-1:0]      gainSel,
  input logic [NUM_CH-1:0]        chanPwdN,
  input logic                     refPwdN,
  input logic [NUM_CH-1:0]        gainBad
);

  // R4: acknowledge lasts exactly one cycle
  a_r4_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ackStrobe |=> !ackStrobe);

  // R2: an acknowledge follows an SCL low-then-high pair of samples
  a_r2_ack_after_rise: assert property (@(posedge clk) disable iff (rst)
    ackStrobe |-> ($past(sclIn, 2) && !$past(sclIn, 3)));

  // R6: bank registers only move in an acknowledge cycle
  a_r6_bank_quiet: assert property (@(posedge clk) disable iff (rst)
    !ackStrobe |-> ($stable(offsetCode) && $stable(gainSel) &&
                    $stable(chanPwdN) && $stable(refPwdN)));

  // R10: illegal-code flags track only the gain codes
  a_r10_flag_follows_gain: assert property (@(posedge clk) disable iff (rst)
    $stable(gainSel) |-> $stable(gainBad));

endmodule

bind i2c_wr_cfg_bank i2c_cfg_chk #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .sclIn(sclIn), .ackStrobe(ackStrobe),
  .offsetCode(offsetCode), .gainSel(gainSel), .chanPwdN(chanPwdN),
  .refPwdN(refPwdN), .gainBad(gainBad)
);

// File: tb/test_i2c_wr_cfg_bank.sv
`timescale 1ns/1ps
module test_i2c_wr_cfg_bank;

  localparam int NCH = 4;
  localparam int NREG = 2 * NCH + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic            ackStrobe;
  logic [NCH*8-1:0] offsetCode;
  logic [NCH*4-1:0] gainSel;
  logic [NCH-1:0]  chanPwdN;
  logic            refPwdN;
  logic [NCH-1:0]  gainBad;

  always #2.5 clk = ~clk;

  i2c_wr_cfg_bank i_i2c_wr_cfg_bank (
    .clk(clk), .rst(rst), .sclIn(scl), .sdaIn(sda), .ackStrobe(ackStrobe),
    .offsetCode(offsetCode), .gainSel(gainSel), .chanPwdN(chanPwdN),
    .refPwdN(refPwdN), .gainBad(gainBad)
  );

  int checks = 0;
  int fails  = 0;
  int ackSeen = 0;
  int ackExp  = 0;
  logic finished = 1'b0;

  logic [7:0] expOff [NCH];
  logic [3:0] expGain[NCH];
  logic       expEn  [NCH];
  logic       expRef;
  logic [7:0] txBuf  [16];

  always @(negedge clk) if (!rst && ackStrobe) ackSeen++;

  function automatic logic legalCode(input logic [3:0] c);
    return (c == 4'b0101) || (c == 4'b0110) || (c == 4'b1001) || (c == 4'b1010);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " offset"}, 32'(offsetCode[c*8 +: 8]), 32'(expOff[c]));
      chk({tag, " gain"},   32'(gainSel[c*4 +: 4]),    32'(expGain[c]));
      chk({tag, " enable"}, 32'(chanPwdN[c]),          32'(expEn[c]));
      chk({tag, " R10 flag"}, 32'(gainBad[c]),         32'(!legalCode(expGain[c])));
    end
    chk({tag, " reference"}, 32'(refPwdN), 32'(expRef));
    chk({tag, " R4 ack count"}, 32'(ackSeen), 32'(ackExp));
  endtask

  task automatic sendStart();
    @(negedge clk) scl = 1'b0;
    @(negedge clk) sda = 1'b1;
    @(negedge clk) scl = 1'b1;
    @(negedge clk);
    @(negedge clk) sda = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendStop();
    @(negedge clk) begin scl = 1'b0; sda = 1'b0; end
    @(negedge clk) scl = 1'b1;
    @(negedge clk);
    @(negedge clk) sda = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk) begin scl = 1'b0; sda = b; end
    @(negedge clk) scl = 1'b1;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sendBit(1'b1);
  endtask

  // Reference model of the bank for one framed transaction
  task automatic modelTx(input logic [7:0] addr, input int n);
    int idx = 0;
    if (addr != 8'h08) return;
    ackExp++;
    for (int k = 0; k < n; k++) begin
      if (idx < NREG) begin
        if (idx == 2 * NCH) expRef = txBuf[k][0];
        else if (idx % 2 == 0) expOff[idx/2] = txBuf[k];
        else begin
          expGain[idx/2] = txBuf[k][3:0];
          expEn[idx/2]   = txBuf[k][7];
        end
        ackExp++;
        idx++;
      end
    end
  endtask

  task automatic runTx(input logic [7:0] addr, input int n, input logic withStop);
    sendStart();
    sendByte(addr);
    for (int k = 0; k < n; k++) sendByte(txBuf[k]);
    if (withStop) sendStop();
    modelTx(addr, n);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    for (int c = 0; c < NCH; c++) begin
      expOff[c] = '0; expGain[c] = '0; expEn[c] = 1'b0;
    end
    expRef = 1'b0;
    seed = $urandom(32'd20240611);

    repeat (5) @(negedge clk);
    chk("R1 ack during reset", 32'(ackStrobe), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    checkAll("R1 reset");

    // Full legal bank, distinct bytes expose order and MSB-first taking
    txBuf[0] = 8'h80; txBuf[1] = 8'h85; txBuf[2] = 8'h01; txBuf[3] = 8'h06;
    txBuf[4] = 8'h3C; txBuf[5] = 8'h89; txBuf[6] = 8'hA5; txBuf[7] = 8'h0A;
    txBuf[8] = 8'h01;
    runTx(8'h08, 9, 1'b1);
    checkAll("R2 R6 R7 R8 full write");

    // Ignored bits 6..4 of control and 7..1 of reference
    txBuf[0] = 8'h11; txBuf[1] = 8'h75; txBuf[2] = 8'h22; txBuf[3] = 8'hF6;
    txBuf[4] = 8'h33; txBuf[5] = 8'h09; txBuf[6] = 8'h44; txBuf[7] = 8'hCA;
    txBuf[8] = 8'hFE;
    runTx(8'h08, 9, 1'b1);
    checkAll("R7 R8 ignored bits");

    // Wrong address and read bit leave everything alone
    for (int k = 0; k < 9; k++) txBuf[k] = 8'hFF;
    runTx(8'h0A, 9, 1'b1);
    checkAll("R5 wrong address");
    runTx(8'h09, 9, 1'b1);
    checkAll("R5 read bit");

    // Overflow: bytes beyond the ninth dropped
    for (int k = 0; k < 13; k++) txBuf[k] = 8'(8'h40 + k);
    txBuf[1] = 8'h85; txBuf[3] = 8'h86;
    runTx(8'h08, 13, 1'b1);
    checkAll("R9 overflow");

    // Illegal gain codes stored and flagged
    txBuf[0] = 8'h00; txBuf[1] = 8'h80; txBuf[2] = 8'h00; txBuf[3] = 8'h8F;
    txBuf[4] = 8'h00; txBuf[5] = 8'h83; txBuf[6] = 8'h00; txBuf[7] = 8'h8C;
    txBuf[8] = 8'h01;
    runTx(8'h08, 9, 1'b1);
    checkAll("R10 illegal gains");

    // Repeated START with no STOP restarts the index
    txBuf[0] = 8'h5A; txBuf[1] = 8'h89; txBuf[2] = 8'hC3;
    runTx(8'h08, 3, 1'b0);
    txBuf[0] = 8'h77; txBuf[1] = 8'h06;
    runTx(8'h08, 2, 1'b1);
    checkAll("R3 repeated start");

    // Randomised transactions
    for (int t = 0; t < 40; t++) begin
      logic [7:0] a;
      int n;
      a = ($urandom % 4 != 0) ? 8'h08 : 8'($urandom);
      n = $urandom % 13;
      for (int k = 0; k < n; k++) begin
        txBuf[k] = 8'($urandom);
        if (($urandom % 2) == 0) txBuf[k][3:0] = 4'b0101 << ($urandom % 2);
      end
      runTx(a, n, 1'b1);
      checkAll("R3 R5 R6 R9 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 got hung exp done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule